// File: doc/BRIEF.md
# Multi-Width Host Bus Word Assembler

This block sits behind the parallel write port of a display controller. A host drives chip select, a register-select line, an active-low write strobe and an 18-bit data bus. Depending on a static port-width selection the host uses 18, 16, 9 or 8 of those pins, and a complete word may take one or two bus beats. The block collects the beats. It loads a completed index word into a 16-bit index register and a completed data word into an 18-bit write-data register. Each finished data word raises a one-clock valid pulse.

Each port width reads its own fixed group of pins. The 16-bit port skips DB9 and DB0. Wide words can be split unevenly: a pixel on the 16-bit port may arrive as 2 bits followed by 16 bits. A beat counter tracks partial words. Deasserting chip select, changing the port width, or switching between index and data mid-word throws a partial word away.

The output side is a valid-only stream. The host bus cannot be stalled, so there is no ready input and no back-pressure. A consumer must accept `wvalid_o` in the cycle it is high. The word stays in `wdata_o` until the next data word completes.

Top module: `host_word_asm`

## Requirements
- R1: After reset `index_o` and `wdata_o` are zero, `wvalid_o` is low, and no partial word is held.
- R2: The port width is selected by `port_mode`: 000 selects 18-bit, 001 selects 9-bit, 010 selects 16-bit and 011 selects 8-bit. Any other code behaves as 18-bit.
- R3: A beat is taken at the rising edge of `wr_n` while `cs_n` is low. `rs` low marks an index beat and `rs` high marks a data beat. Strobes while `cs_n` is high have no effect.
- R4: In 18-bit mode a data word is DB17-DB0 in one beat. An index word is the packed 16 bits {DB17-DB10, DB8-DB1} in one beat.
- R5: In 16-bit mode the packed 16 bits are {DB17-DB10, DB8-DB1}, and DB9 and DB0 are ignored. With `split16` low, a data beat is read as 5-6-5 colour and widened to 18 bits as {p[15:11], p[15], p[10:5], p[4:0], p[4]}. An index is the packed value.
- R6: In 16-bit mode with `split16` high, a data word takes two beats. The first beat's packed bits 1:0 (pins DB2-DB1) become word bits 17:16. The second beat's packed 16 bits become bits 15:0.
- R7: In 9-bit mode a data word takes two beats on DB17-DB9. The first beat gives word bits 17:9 and the second gives bits 8:0.
- R8: In 8-bit and 9-bit modes an index takes two beats on DB17-DB10, upper byte first. DB9 is ignored for index beats.
- R9: In 8-bit mode a data word takes two bytes on DB17-DB10, upper byte first. The resulting 16 bits are widened as in R5.
- R10: `wvalid_o` pulses for exactly one clock after the final beat of each data word, and never for index words or partial words. `wdata_o` changes only with that pulse.
- R11: Deasserting `cs_n` discards a partial word.
- R12: A change of `port_mode` discards a partial word.
- R13: A beat whose `rs` differs from a pending partial word discards the partial word and starts a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_mode | input | 3 | Static port-width select |
| split16 | input | 1 | 16-bit mode: data in two beats (2 then 16 bits) |
| cs_n | input | 1 | Active-low chip select |
| rs | input | 1 | Register select: 0 index, 1 data |
| wr_n | input | 1 | Active-low write strobe, sampled on its rising edge |
| db | input | 18 | Host data bus |
| index_o | output | 16 | Index register |
| wdata_o | output | 18 | Write-data register |
| wvalid_o | output | 1 | One-clock pulse per completed data word |

## Verification
Every width is driven with both index and data words. Junk is placed on the pins that width must ignore, so a wrong pin map shows as a wrong value and not as a lucky match. The asymmetric 5-6-5 patterns separate the red and blue widening from a swapped or shifted field. The split-pixel and two-beat cases check beat order, because the first-beat bits land only in the upper bits. Chip-select release, a mode change and an `rs` switch each follow a single dangling beat. A block that keeps the partial word would then produce either a spurious pulse or a word mixed from both sides.

// File: rtl/hwa_pkg.sv
package hwa_pkg;
  localparam int BUS_W  = 18;
  localparam int IDX_W  = 16;
  localparam int HALF_W = BUS_W / 2;

  typedef enum logic [2:0] {
    PM_W18 = 3'b000,
    PM_W9  = 3'b001,
    PM_W16 = 3'b010,
    PM_W8  = 3'b011
  } pmode_e;

  function automatic pmode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b001:  return PM_W9;
      3'b010:  return PM_W16;
      3'b011:  return PM_W8;
      default: return PM_W18;
    endcase
  endfunction

  // packed 16-bit field: upper byte on DB17-DB10, lower byte on DB8-DB1
  function automatic logic [IDX_W-1:0] pack16(input logic [BUS_W-1:0] d);
    return {d[17:10], d[8:1]};
  endfunction

  // 5-6-5 to 6-6-6 by repeating red and blue MSBs
  function automatic logic [BUS_W-1:0] widen565(input logic [IDX_W-1:0] p);
    return {p[15:11], p[15], p[10:5], p[4:0], p[4]};
  endfunction
endpackage

// File: rtl/hwa_bus_sampler.sv
module hwa_bus_sampler
  import hwa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rs,
  input  logic             wr_n,
  input  logic [BUS_W-1:0] db,
  output logic             stb,
  output logic             stb_rs,
  output logic             bus_idle,
  output logic [BUS_W-1:0] stb_db
);
  logic             s1_cs, s1_wr, s1_rs;
  logic             s2_cs, s2_wr, s2_rs;
  logic [BUS_W-1:0] s1_db, s2_db;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_cs <= 1'b1; s1_wr <= 1'b1; s1_rs <= 1'b0; s1_db <= '0;
      s2_cs <= 1'b1; s2_wr <= 1'b1; s2_rs <= 1'b0; s2_db <= '0;
    end else begin
      s1_cs <= cs_n; s1_wr <= wr_n; s1_rs <= rs; s1_db <= db;
      s2_cs <= s1_cs; s2_wr <= s1_wr; s2_rs <= s1_rs; s2_db <= s1_db;
    end
  end

  // rising edge of the strobe; data and select come from the low phase
  assign stb      = s1_wr & ~s2_wr & ~s2_cs;
  assign stb_rs   = s2_rs;
  assign stb_db   = s2_db;
  assign bus_idle = s2_cs;

  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/hwa_beat_packer.sv
module hwa_beat_packer
  import hwa_pkg::*;
(
  input  pmode_e            mode,
  input  logic              split16,
  input  logic              rs,
  input  logic [BUS_W-1:0]  db,
  input  logic [HALF_W-1:0] acc,
  output logic              two_beat,
  output logic [HALF_W-1:0] stash,
  output logic [IDX_W-1:0]  fin_idx,
  output logic [BUS_W-1:0]  fin_word
);
  logic [IDX_W-1:0] pk;
  logic [7:0]       byte_in;

  assign pk      = pack16(db);
  assign byte_in = db[17:10];

  always_comb begin
    two_beat = 1'b0;
    stash    = '0;
    fin_idx  = pk;
    fin_word = db;
    case (mode)
      PM_W16: begin
        two_beat = rs & split16;
        stash    = {{(HALF_W-2){1'b0}}, pk[1:0]};
        fin_word = two_beat ? {acc[1:0], pk} : widen565(pk);
      end
      PM_W9: begin
        two_beat = 1'b1;
        stash    = rs ? db[17:9] : {1'b0, byte_in};
        fin_idx  = {acc[7:0], byte_in};
        fin_word = {acc, db[17:9]};
      end
      PM_W8: begin
        two_beat = 1'b1;
        stash    = {1'b0, byte_in};
        fin_idx  = {acc[7:0], byte_in};
        fin_word = widen565({acc[7:0], byte_in});
      end
      default: begin
        two_beat = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/hwa_word_builder.sv
module hwa_word_builder
  import hwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pmode_e            mode,
  input  logic              stb,
  input  logic              stb_rs,
  input  logic              bus_idle,
  input  logic              two_beat,
  input  logic [HALF_W-1:0] stash,
  input  logic [IDX_W-1:0]  fin_idx,
  input  logic [BUS_W-1:0]  fin_word,
  output logic [HALF_W-1:0] acc_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BUS_W-1:0]  word_o,
  output logic              vld_o
);
  pmode_e mode_q;
  logic   cnt_q;
  logic   kind_q;
  logic   restart, cont, finish;

  assign restart = (mode != mode_q) | bus_idle;
  assign cont    = cnt_q & (kind_q == stb_rs);
  assign finish  = stb & (~two_beat | cont);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_W18;
      cnt_q  <= 1'b0;
      kind_q <= 1'b0;
      acc_o  <= '0;
      idx_o  <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      mode_q <= mode;
      vld_o  <= 1'b0;
      if (restart) begin
        cnt_q <= 1'b0;
      end else if (finish) begin
        cnt_q <= 1'b0;
        if (stb_rs) begin
          word_o <= fin_word;
          vld_o  <= 1'b1;
        end else begin
          idx_o <= fin_idx;
        end
      end else if (stb) begin
        cnt_q  <= 1'b1;
        kind_q <= stb_rs;
        acc_o  <= stash;
      end
    end
  end

  // R10
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> $stable(word_o));
  // R10
  vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(stb && stb_rs));
  // R12
  mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> !cnt_q);
  // R11
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |=> !cnt_q);
endmodule

// File: rtl/host_word_asm.sv
module host_word_asm
  import hwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        port_mode,
  input  logic              split16,
  input  logic              cs_n,
  input  logic              rs,
  input  logic              wr_n,
  input  logic [BUS_W-1:0]  db,
  output logic [IDX_W-1:0]  index_o,
  output logic [BUS_W-1:0]  wdata_o,
  output logic              wvalid_o
);
  pmode_e            mode;
  logic              stb, stb_rs, bus_idle, two_beat;
  logic [BUS_W-1:0]  stb_db, fin_word;
  logic [HALF_W-1:0] stash, acc;
  logic [IDX_W-1:0]  fin_idx;

  assign mode = decode_mode(port_mode);

  hwa_bus_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n), .db(db),
    .stb(stb), .stb_rs(stb_rs), .bus_idle(bus_idle), .stb_db(stb_db)
  );

  hwa_beat_packer u_pack (
    .mode(mode), .split16(split16), .rs(stb_rs), .db(stb_db), .acc(acc),
    .two_beat(two_beat), .stash(stash), .fin_idx(fin_idx), .fin_word(fin_word)
  );

  hwa_word_builder u_bld (
    .clk(clk), .rst_n(rst_n), .mode(mode), .stb(stb), .stb_rs(stb_rs),
    .bus_idle(bus_idle), .two_beat(two_beat), .stash(stash),
    .fin_idx(fin_idx), .fin_word(fin_word), .acc_o(acc),
    .idx_o(index_o), .word_o(wdata_o), .vld_o(wvalid_o)
  );

  // R3
  idx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (index_o != $past(index_o)) |-> $past(stb && !stb_rs));
endmodule

// File: tb/sim_host_word_asm.sv
module sim_host_word_asm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  port_mode = 3'b000;
  logic        split16 = 1'b0;
  logic        cs_n = 1'b1;
  logic        rs = 1'b0;
  logic        wr_n = 1'b1;
  logic [17:0] db = '0;
  logic [15:0] index_o;
  logic [17:0] wdata_o;
  logic        wvalid_o;

  int checks = 0;
  int errors = 0;
  int vld_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  host_word_asm u0 (
    .clk(clk), .rst_n(rst_n), .port_mode(port_mode), .split16(split16),
    .cs_n(cs_n), .rs(rs), .wr_n(wr_n), .db(db),
    .index_o(index_o), .wdata_o(wdata_o), .wvalid_o(wvalid_o)
  );

  always @(negedge clk) if (rst_n && wvalid_o) vld_cnt++;

  function automatic logic [17:0] wid(input logic [15:0] p);
    return {p[15:11], p[15], p[10:5], p[4:0], p[4]};
  endfunction
  function automatic logic [17:0] p16(input logic [15:0] v);
    return {v[15:8], 1'b1, v[7:0], 1'b1};
  endfunction
  function automatic logic [17:0] p9(input logic [8:0] v);
    return {v, 9'h155};
  endfunction
  function automatic logic [17:0] p8(input logic [7:0] v);
    return {v, 10'h2AA};
  endfunction
  function automatic logic [17:0] s2(input logic [1:0] v);
    return {8'hA5, 1'b1, 6'b101101, v, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic r, input logic [17:0] d);
    @(negedge clk); cs_n = 1'b0; rs = r; db = d; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_cs();
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m, input logic sp);
    @(negedge clk); port_mode = m; split16 = sp;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 index", index_o, 0);
    chk("R1 wdata", wdata_o, 0);
    chk("R1 valid count", vld_cnt, 0);
  endtask

  task automatic t_w18();
    int c0;
    set_mode(3'b000, 1'b0);
    c0 = vld_cnt;
    beat(1'b1, 18'h2D3C5); release_cs();
    chk("R4 data word", wdata_o, 18'h2D3C5);
    chk("R10 one pulse", vld_cnt, c0 + 1);
    beat(1'b0, p16(16'hBEEF)); release_cs();
    chk("R4 index", index_o, 16'hBEEF);
    chk("R10 no pulse on index", vld_cnt, c0 + 1);
  endtask

  task automatic t_w16();
    int c0;
    set_mode(3'b010, 1'b0);
    c0 = vld_cnt;
    beat(1'b1, p16(16'hF81F)); release_cs();
    chk("R5 widened data", wdata_o, wid(16'hF81F));
    beat(1'b1, p16(16'h07E2)); release_cs();
    chk("R5 widened data 2", wdata_o, wid(16'h07E2));
    chk("R5 pulses", vld_cnt, c0 + 2);
    beat(1'b0, p16(16'h1234)); release_cs();
    chk("R5 index", index_o, 16'h1234);
  endtask

  task automatic t_split();
    int c0;
    set_mode(3'b010, 1'b1);
    c0 = vld_cnt;
    beat(1'b1, s2(2'b10));
    chk("R6 no pulse after first beat", vld_cnt, c0);
    beat(1'b1, p16(16'h5A5A)); release_cs();
    chk("R6 split word", wdata_o, 18'h25A5A);
    chk("R6 one pulse", vld_cnt, c0 + 1);
  endtask

  task automatic t_w9();
    int c0;
    set_mode(3'b001, 1'b0);
    c0 = vld_cnt;
    beat(1'b1, p9(9'h1C3));
    chk("R7 no pulse after half", vld_cnt, c0);
    beat(1'b1, p9(9'h02E)); release_cs();
    chk("R7 data word", wdata_o, {9'h1C3, 9'h02E});
    chk("R7 one pulse", vld_cnt, c0 + 1);
    beat(1'b0, p8(8'hC0)); beat(1'b0, p8(8'hDE)); release_cs();
    chk("R8 9-bit index", index_o, 16'hC0DE);
  endtask

  task automatic t_w8();
    int c0;
    set_mode(3'b011, 1'b0);
    c0 = vld_cnt;
    beat(1'b0, p8(8'h7E)); beat(1'b0, p8(8'h81)); release_cs();
    chk("R8 8-bit index", index_o, 16'h7E81);
    beat(1'b1, p8(8'h07)); beat(1'b1, p8(8'hE0)); release_cs();
    chk("R9 8-bit data", wdata_o, wid(16'h07E0));
    chk("R9 one pulse", vld_cnt, c0 + 1);
  endtask

  task automatic t_cs_drop();
    int c0;
    set_mode(3'b001, 1'b0);
    c0 = vld_cnt;
    beat(1'b1, p9(9'h111)); release_cs();
    beat(1'b1, p9(9'h0F0));
    chk("R11 no pulse after restart beat", vld_cnt, c0);
    beat(1'b1, p9(9'h10F)); release_cs();
    chk("R11 fresh word", wdata_o, {9'h0F0, 9'h10F});
    chk("R11 one pulse", vld_cnt, c0 + 1);
  endtask

  task automatic t_mode_drop();
    int c0;
    set_mode(3'b001, 1'b0);
    c0 = vld_cnt;
    beat(1'b1, p9(9'h155));
    set_mode(3'b011, 1'b0);
    beat(1'b1, p8(8'hF8));
    chk("R12 no pulse after first 8-bit beat", vld_cnt, c0);
    beat(1'b1, p8(8'h00)); release_cs();
    chk("R12 fresh word", wdata_o, wid(16'hF800));
    chk("R12 one pulse", vld_cnt, c0 + 1);
  endtask

  task automatic t_rs_switch();
    int c0;
    logic [15:0] idx0;
    set_mode(3'b001, 1'b0);
    c0 = vld_cnt;
    idx0 = index_o;
    beat(1'b0, p8(8'hAA));
    beat(1'b1, p9(9'h1A5));
    chk("R13 no pulse yet", vld_cnt, c0);
    beat(1'b1, p9(9'h05A)); release_cs();
    chk("R13 index kept", index_o, idx0);
    chk("R13 data word", wdata_o, {9'h1A5, 9'h05A});
  endtask

  task automatic t_cs_high();
    int c0;
    logic [17:0] w0;
    set_mode(3'b000, 1'b0);
    c0 = vld_cnt;
    w0 = wdata_o;
    @(negedge clk); cs_n = 1'b1; rs = 1'b1; db = 18'h3A5A5; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 data kept with cs high", wdata_o, w0);
    chk("R3 no pulse with cs high", vld_cnt, c0);
  endtask

  task automatic t_bad_code();
    set_mode(3'b111, 1'b0);
    beat(1'b1, 18'h1ABCD); release_cs();
    chk("R2 reserved code as 18-bit", wdata_o, 18'h1ABCD);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_w18();
    t_w16();
    t_split();
    t_w9();
    t_w8();
    t_cs_drop();
    t_mode_drop();
    t_rs_switch();
    t_cs_high();
    t_bad_code();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      report();
    end
  end
endmodule